// File: doc/BRIEF.md
# Periodic Comparator Event Timer

This block is a register-mapped event timer. One 64-bit up-counter advances by one on every clock while the global run bit is set, and two 32-bit comparator channels watch it. When the counter steps onto a channel's comparator value, that channel records an event in a status register and, if its interrupt is enabled, raises an interrupt line. Channel 0 can run periodically: each event adds a stored interval to its comparator, so the counter never has to be reset between events. Channel 1 fires once per programmed value.

Software reaches everything through a single-cycle register bus: a write strobe with address and data, and a read port whose data follows the address within the same cycle. A legacy-routing bit in the global configuration steers channel 0 onto a dedicated system-tick line and channel 1 onto a dedicated real-time-clock line, in place of the per-channel lines. An arming bit in a channel's configuration turns the next two comparator writes into an interval load followed by a comparator load.

Top module: `evt_timer`

Register offsets (byte addresses, 32-bit words): 0x00 capabilities, 0x04 tick period, 0x08 global configuration (bit 0 run, bit 1 legacy routing), 0x0C event status (bit n for channel n, write 1 to clear), 0x10 counter bits 31:0, 0x14 counter bits 63:32. Channel n uses base 0x20 + 0x10*n: +0x0 configuration, +0x4 comparator, +0x8 interval readback.

## Requirements
- R1: While the run bit (0x08 bit 0) is clear the counter holds its value; writes to 0x10 and 0x14 load the low and high halves, and both halves read back as written.
- R2: While the run bit is set the counter increases by exactly one per clock, and writes to 0x10 and 0x14 are ignored.
- R3: Writing a channel configuration with the arming bit (bit 6) set makes the next comparator write load the interval and the following one load the comparator; the arming bit reads back as 1 until that second write and as 0 afterwards.
- R4: In periodic mode (configuration bit 3, channel 0 only) every event adds the interval to the comparator, while the counter keeps running.
- R5: Channel 1 is one-shot: its comparator is unchanged by an event, and after the status is cleared no further event occurs until the counter returns to that value.
- R6: An event sets the channel's status bit in 0x0C on the clock the counter reaches the comparator value; writing 1 to that bit clears it.
- R7: A channel drives an interrupt only while its status bit and its interrupt-enable bit (configuration bit 2) are both set.
- R8: With the legacy bit (0x08 bit 1) set, channel 0 drives the system-tick line and channel 1 the real-time-clock line, and the per-channel lines stay low; with it clear, the reverse.
- R9: With the 32-bit compare bit (configuration bit 8) set only counter bits 31:0 are compared; with it clear an event also needs counter bits 63:32 to be zero.
- R10: The capabilities word reports channel count minus one in bits 12:8 and a legacy-routing-capable flag in bit 15; 0x04 returns the tick period in femtoseconds; channel configuration bits 13:9 report the route number, bit 4 reports periodic capability.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Byte address of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, same cycle |
| chanIrq | output | 2 | Per-channel interrupt lines (legacy routing off) |
| sysTickIrq | output | 1 | System-tick line (channel 0, legacy routing on) |
| rtcIrq | output | 1 | Real-time-clock line (channel 1, legacy routing on) |

## Verification
The assertions assume software never writes a comparator and the counter in the same clock in a way that races an event, and that addresses are word aligned; the bench issues one register access per clock at aligned offsets only. Counter writes are made only with the run bit clear, except for the one deliberate write that checks it is ignored. Comparator targets are placed tens of cycles ahead of the running counter so each event falls in a known window between reads.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int NUM_CH = 2;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 64;
  localparam int ADDR_W = 8;
  localparam logic [NUM_CH-1:0] PER_CAP = 2'b01;

  localparam logic [ADDR_W-1:0] A_CAPS   = 8'h00;
  localparam logic [ADDR_W-1:0] A_TICK   = 8'h04;
  localparam logic [ADDR_W-1:0] A_GCFG   = 8'h08;
  localparam logic [ADDR_W-1:0] A_STAT   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_CNTLO  = 8'h10;
  localparam logic [ADDR_W-1:0] A_CNTHI  = 8'h14;
  localparam logic [ADDR_W-1:0] A_CHBASE = 8'h20;
  localparam int CH_STRIDE = 16;

  localparam int B_INTEN  = 2;
  localparam int B_PERIOD = 3;
  localparam int B_PERCAP = 4;
  localparam int B_ARM    = 6;
  localparam int B_MODE32 = 8;
  localparam int B_ROUTE  = 9;

  typedef enum logic [1:0] {ARM_IDLE, ARM_WANT_IVL, ARM_WANT_CMP} armPhase_t;

  typedef struct packed {
    logic              wrGcfg;
    logic              wrStat;
    logic              wrCntLo;
    logic              wrCntHi;
    logic [NUM_CH-1:0] wrCfg;
    logic [NUM_CH-1:0] ldCmp;
    logic [NUM_CH-1:0] ldIvl;
    logic [DATA_W-1:0] data;
  } strobe_t;

  typedef struct packed {
    logic                          runOn;
    logic                          legacyOn;
    logic [NUM_CH-1:0]             status;
    logic [NUM_CH-1:0]             intEn;
    logic [NUM_CH-1:0]             periodic;
    logic [NUM_CH-1:0]             mode32;
    logic [CNT_W-1:0]              counter;
    logic [NUM_CH-1:0][DATA_W-1:0] cmp;
    logic [NUM_CH-1:0][DATA_W-1:0] ivl;
  } dpState_t;
endpackage

// File: rtl/evt_timer_dp.sv
module evt_timer_dp
  import evt_timer_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  strobe_t  stb,
  output dpState_t st
);
  logic [CNT_W-1:0]  cntNext;
  logic [NUM_CH-1:0] match;

  assign cntNext = st.counter + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st.counter  <= '0;
      st.runOn    <= 1'b0;
      st.legacyOn <= 1'b0;
    end else begin
      if (stb.wrGcfg) begin
        st.runOn    <= stb.data[0];
        st.legacyOn <= stb.data[1];
      end
      if (st.runOn) begin
        st.counter <= cntNext;
      end else begin
        if (stb.wrCntLo) st.counter[DATA_W-1:0]     <= stb.data;
        if (stb.wrCntHi) st.counter[CNT_W-1:DATA_W] <= stb.data;
      end
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : gChan
    logic hiOk;
    assign hiOk     = st.mode32[n] | (cntNext[CNT_W-1:DATA_W] == '0);
    assign match[n] = st.runOn & hiOk & (cntNext[DATA_W-1:0] == st.cmp[n]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        st.status[n]   <= 1'b0;
        st.intEn[n]    <= 1'b0;
        st.periodic[n] <= 1'b0;
        st.mode32[n]   <= 1'b0;
        st.cmp[n]      <= '1;
        st.ivl[n]      <= '0;
      end else begin
        if (match[n])                          st.status[n] <= 1'b1;
        else if (stb.wrStat && stb.data[n])    st.status[n] <= 1'b0;
        if (stb.wrCfg[n]) begin
          st.intEn[n]    <= stb.data[B_INTEN];
          st.periodic[n] <= stb.data[B_PERIOD] & PER_CAP[n];
          st.mode32[n]   <= stb.data[B_MODE32];
        end
        if (stb.ldIvl[n]) st.ivl[n] <= stb.data;
        if (stb.ldCmp[n])                      st.cmp[n] <= stb.data;
        else if (match[n] && st.periodic[n])   st.cmp[n] <= st.cmp[n] + st.ivl[n];
      end
    end

    AST_EVENT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
      match[n] |=> st.status[n]); // R6
    AST_ONESHOT_CMP_HELD: assert property (@(posedge clk) disable iff (!rstN)
      (match[n] && !st.periodic[n] && !stb.ldCmp[n]) |=> $stable(st.cmp[n])); // R5
    AST_PERIODIC_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
      (match[n] && st.periodic[n] && !stb.ldCmp[n])
        |=> st.cmp[n] == $past(st.cmp[n]) + $past(st.ivl[n])); // R4
  end

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!st.runOn && !stb.wrCntLo && !stb.wrCntHi) |=> $stable(st.counter)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    st.runOn |=> st.counter == $past(st.counter) + 64'd1); // R2
endmodule

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl
  import evt_timer_pkg::*;
#(
  parameter logic [31:0] TICK_FS    = 32'd69841279,
  parameter int          ROUTE_BASE = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  dpState_t          st,
  output strobe_t           stb,
  output logic [DATA_W-1:0] regRdData
);
  localparam logic [4:0] CH_FIELD = 5'(NUM_CH - 1);

  armPhase_t         phase [NUM_CH];
  logic [NUM_CH-1:0] selCfg, selCmp, selIvl;

  for (genvar n = 0; n < NUM_CH; n++) begin : gDec
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(int'(A_CHBASE) + n * CH_STRIDE);
    assign selCfg[n] = (regAddr == BASE);
    assign selCmp[n] = (regAddr == BASE + 8'h4);
    assign selIvl[n] = (regAddr == BASE + 8'h8);

    always_comb begin
      stb.wrCfg[n] = regWrEn & selCfg[n];
      stb.ldIvl[n] = regWrEn & selCmp[n] & (phase[n] == ARM_WANT_IVL);
      stb.ldCmp[n] = regWrEn & selCmp[n] & (phase[n] != ARM_WANT_IVL);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        phase[n] <= ARM_IDLE;
      end else if (stb.wrCfg[n] && regWrData[B_ARM]) begin
        phase[n] <= ARM_WANT_IVL;
      end else if (regWrEn && selCmp[n]) begin
        case (phase[n])
          ARM_WANT_IVL: phase[n] <= ARM_WANT_CMP;
          default:      phase[n] <= ARM_IDLE;
        endcase
      end
    end

    AST_ARM_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (phase[n] == ARM_WANT_CMP && regWrEn && selCmp[n] && !selCfg[n])
        |=> phase[n] == ARM_IDLE); // R3
  end

  always_comb begin
    stb.wrGcfg  = regWrEn & (regAddr == A_GCFG);
    stb.wrStat  = regWrEn & (regAddr == A_STAT);
    stb.wrCntLo = regWrEn & (regAddr == A_CNTLO);
    stb.wrCntHi = regWrEn & (regAddr == A_CNTHI);
    stb.data    = regWrData;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_CAPS:  begin
        regRdData[12:8] = CH_FIELD;
        regRdData[15]   = 1'b1;
      end
      A_TICK:  regRdData = TICK_FS;
      A_GCFG:  regRdData = {30'd0, st.legacyOn, st.runOn};
      A_STAT:  regRdData = DATA_W'(st.status);
      A_CNTLO: regRdData = st.counter[DATA_W-1:0];
      A_CNTHI: regRdData = st.counter[CNT_W-1:DATA_W];
      default: regRdData = '0;
    endcase
    for (int n = 0; n < NUM_CH; n++) begin
      if (selCfg[n]) begin
        regRdData              = '0;
        regRdData[B_INTEN]     = st.intEn[n];
        regRdData[B_PERIOD]    = st.periodic[n];
        regRdData[B_PERCAP]    = PER_CAP[n];
        regRdData[B_ARM]       = (phase[n] != ARM_IDLE);
        regRdData[B_MODE32]    = st.mode32[n];
        regRdData[B_ROUTE+:5]  = 5'(ROUTE_BASE + n);
      end
      if (selCmp[n]) regRdData = st.cmp[n];
      if (selIvl[n]) regRdData = st.ivl[n];
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter logic [31:0] TICK_FS    = 32'd69841279,
  parameter int          ROUTE_BASE = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic [1:0]  chanIrq,
  output logic        sysTickIrq,
  output logic        rtcIrq
);
  strobe_t           stb;
  dpState_t          st;
  logic [NUM_CH-1:0] irqRaw;

  evt_timer_ctrl #(.TICK_FS(TICK_FS), .ROUTE_BASE(ROUTE_BASE)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .st(st), .stb(stb), .regRdData(regRdData)
  );

  evt_timer_dp uDp (.clk(clk), .rstN(rstN), .stb(stb), .st(st));

  assign irqRaw     = st.status & st.intEn;
  assign chanIrq    = st.legacyOn ? '0 : irqRaw;
  assign sysTickIrq = st.legacyOn & irqRaw[0];
  assign rtcIrq     = st.legacyOn & irqRaw[1];

  AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (|{chanIrq, sysTickIrq, rtcIrq}) |-> (|st.status)); // R7
  AST_ROUTES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (sysTickIrq || rtcIrq) |-> (chanIrq == 2'b00)); // R8
endmodule

// File: tb/evt_timer_test.sv
module evt_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [1:0]  chanIrq;
  logic        sysTickIrq, rtcIrq;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  localparam logic [31:0] TICK = 32'd69841279;

  evt_timer #(.TICK_FS(TICK), .ROUTE_BASE(20)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .chanIrq(chanIrq),
    .sysTickIrq(sysTickIrq), .rtcIrq(rtcIrq)
  );

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h08, d); check("R1 reset gcfg", d, 0);
    rd(8'h10, d); check("R1 reset counter", d, 0);
    check("R7 reset irq", {chanIrq, sysTickIrq, rtcIrq}, 0);
  endtask

  task automatic t_caps();
    logic [31:0] d;
    rd(8'h00, d); check("R10 channels-1", d[12:8], 1);
    check("R10 legacy capable", d[15], 1);
    rd(8'h04, d); check("R10 tick period", d, TICK);
    rd(8'h20, d); check("R10 ch0 route", d[13:9], 20);
    check("R10 ch0 periodic cap", d[4], 1);
    rd(8'h30, d); check("R10 ch1 route", d[13:9], 21);
    check("R10 ch1 periodic cap", d[4], 0);
  endtask

  task automatic t_frozen();
    logic [31:0] d;
    wr(8'h10, 32'h0000_1234);
    wr(8'h14, 32'h0000_0005);
    idle(5);
    rd(8'h10, d); check("R1 counter lo held", d, 32'h1234);
    rd(8'h14, d); check("R1 counter hi held", d, 5);
  endtask

  task automatic t_running();
    logic [31:0] c1, c2;
    wr(8'h14, 0); wr(8'h10, 0);
    wr(8'h08, 1);
    rd(8'h10, c1); idle(10); rd(8'h10, c2);
    check("R2 ten steps", c2 - c1, 10);
    rd(8'h10, c1); wr(8'h10, 32'hABCD_0000); rd(8'h10, c2);
    check("R2 write ignored while running", c2 - c1, 1);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    wr(8'h08, 0); wr(8'h10, 0); wr(8'h14, 0);
    wr(8'h20, 32'h14C);
    rd(8'h20, d); check("R3 armed reads 1", d[6], 1);
    wr(8'h24, 100);
    rd(8'h20, d); check("R3 still armed after first", d[6], 1);
    wr(8'h24, 100);
    rd(8'h20, d); check("R3 arm self-clears", d[6], 0);
    rd(8'h28, d); check("R3 interval loaded", d, 100);
    rd(8'h24, d); check("R3 comparator loaded", d, 100);
    wr(8'h0C, 3);
    wr(8'h08, 1);
    idle(110);
    rd(8'h0C, d); check("R6 status set", d[0], 1);
    rd(8'h24, d); check("R4 cmp advanced once", d, 200);
    check("R7 chan irq 0", chanIrq[0], 1);
    rd(8'h10, d); check("R4 counter kept running", d > 100, 1);
    wr(8'h0C, 1);
    rd(8'h0C, d); check("R6 W1C clears", d[0], 0);
    check("R7 irq drops", chanIrq[0], 0);
    idle(100);
    rd(8'h24, d); check("R4 cmp advanced twice", d, 300);
    rd(8'h0C, d); check("R6 status again", d[0], 1);
  endtask

  task automatic t_oneshot();
    logic [31:0] c, d;
    rd(8'h10, c);
    wr(8'h30, 32'h10C);
    wr(8'h34, c + 40);
    idle(50);
    rd(8'h0C, d); check("R5 ch1 event", d[1], 1);
    rd(8'h34, d); check("R5 cmp unchanged", d, c + 40);
    rd(8'h30, d); check("R5 periodic bit stays 0", d[3], 0);
    check("R7 ch1 irq", chanIrq[1], 1);
    wr(8'h0C, 2);
    idle(50);
    rd(8'h0C, d); check("R5 no rematch", d[1], 0);
  endtask

  task automatic t_legacy();
    wr(8'h08, 3);
    idle(110);
    check("R8 sys tick line", sysTickIrq, 1);
    check("R8 per-channel lines low", chanIrq, 0);
    check("R8 rtc line idle", rtcIrq, 0);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    wr(8'h20, 32'h108);
    wr(8'h08, 1);
    idle(110);
    rd(8'h0C, d); check("R7 status set w/o enable", d[0], 1);
    check("R7 gated off", chanIrq[0], 0);
    check("R8 legacy off lines", {sysTickIrq, rtcIrq}, 0);
  endtask

  task automatic t_mode32();
    logic [31:0] d;
    wr(8'h08, 0); wr(8'h10, 0); wr(8'h14, 1);
    wr(8'h34, 20); wr(8'h30, 32'h004); wr(8'h0C, 3);
    wr(8'h08, 1);
    idle(40);
    rd(8'h0C, d); check("R9 64-bit no match", d[1], 0);
    rd(8'h14, d); check("R1 hi half loaded", d, 1);
    wr(8'h08, 0); wr(8'h10, 0); wr(8'h14, 1);
    wr(8'h30, 32'h104); wr(8'h0C, 3);
    wr(8'h08, 1);
    idle(40);
    rd(8'h0C, d); check("R9 32-bit match", d[1], 1);
  endtask

  initial begin
    fork
      begin
        idle(3); rstN = 1'b1; idle(1);
        t_reset(); t_caps(); t_frozen(); t_running(); t_periodic();
        t_oneshot(); t_legacy(); t_gate(); t_mode32();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          nChecks++; nFails++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule